// File: doc/BRIEF.md
# Big-Endian Load Data Extender

This block takes one 64-bit word read from data memory and turns it into the 64-bit value that a load writes back to the register file. From the byte address it selects the bytes that the load asks for, counting bytes big-endian, so the lowest address in the word is its most significant byte. It then widens the selected value to 64 bits. Sign extension or zero extension is chosen per load. A separate high-half load instead puts a 32-bit value in the upper half and clears the lower half.

Each request arrives with a valid strobe. The result is registered, with exactly one cycle from the input strobe to the output strobe. Address arithmetic, caches and the memory array lie outside the block. The load size is encoded on a 2-bit field: 0 is byte, 1 is 16-bit wyde, 2 is 32-bit tetra, and 3 is 64-bit octa.

Top module: `be_load_extender`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_data` become 0.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: Byte lanes are big-endian. Address bits 2:0 select the lane, and offset 0 maps to word bits 63:56. Offset k maps to bits 63-8k down to 56-8k.
- R4: Address bits below the access size are ignored. A wyde ignores bit 0, a tetra ignores bits 1:0, and an octa ignores bits 2:0. Address bits above bit 2 never affect the result.
- R5: With `ld_signed`=1 and size byte, wyde or tetra, the loaded value is sign-extended to 64 bits.
- R6: With `ld_signed`=0 and size byte, wyde or tetra, the loaded value is zero-extended to 64 bits.
- R7: With size octa (3) and `ld_high`=0, `out_data` equals `mem_word`, whatever the value of `ld_signed`.
- R8: With `ld_high`=1, the tetra selected by address bit 2 goes to `out_data[63:32]` and `out_data[31:0]` is 0. `ld_size` and `ld_signed` have no effect.
- R9: In a cycle after `in_valid` was low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| addr | input | 64 | Byte address of the load |
| mem_word | input | 64 | 8-byte aligned word read from memory |
| ld_size | input | 2 | Access size: 0 byte, 1 wyde, 2 tetra, 3 octa |
| ld_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| ld_high | input | 1 | High-half tetra load |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 64 | Write-back value |

## Verification
The only state in this block is the output register and its valid flag. A wrong lane offset, extension bit or strobe therefore shows up at the ports on the very next cycle after the request that caused it. A stale or corrupted held value shows up during the first idle cycle that follows. The model is checked every clock against directed lane and extension corners and against a long random stream, so no fault can stay hidden for more than one cycle.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WYDE  = 2'd1,
        SZ_TETRA = 2'd2,
        SZ_OCTA  = 2'd3
    } ld_size_e;

    typedef struct packed {
        ld_size_e size;
        logic     sign_ext;
        logic     high_half;
    } ld_kind_t;

    // A high-half load always reads one tetra.
    function automatic ld_size_e eff_size(ld_kind_t k);
        return k.high_half ? SZ_TETRA : k.size;
    endfunction

endpackage

// File: rtl/ldx_lane_pick.sv
module ldx_lane_pick
    import ldx_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int OFF_W = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [OFF_W-1:0]  off,
    input  ld_size_e          size,
    output logic [DATA_W-1:0] raw
);
    logic [OFF_W-1:0]  low_mask;
    logic [OFF_W-1:0]  algn;
    logic [DATA_W-1:0] shifted;
    int unsigned       nbits;

    always_comb begin
        // Clear the offset bits below the access size.
        low_mask = OFF_W'((4'd1 << size) - 4'd1);
        algn     = off & ~low_mask;
        // The addressed byte moves to the top, then the field is right-justified.
        shifted  = word << {algn, 3'b000};
        nbits    = 32'd8 << size;
        raw      = shifted >> (DATA_W - nbits);
    end
endmodule

// File: rtl/ldx_extend.sv
module ldx_extend
    import ldx_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int HALF = DATA_W / 2
) (
    input  logic [DATA_W-1:0] raw,
    input  ld_kind_t          kind,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] cand [4];

    for (genvar g = 0; g < 4; g++) begin : g_size
        localparam int W = 8 << g;
        if (W < DATA_W) begin : g_ext
            assign cand[g] = kind.sign_ext
                ? {{(DATA_W-W){raw[W-1]}}, raw[W-1:0]}
                : {{(DATA_W-W){1'b0}},     raw[W-1:0]};
        end else begin : g_full
            assign cand[g] = raw;
        end
    end

    always_comb begin
        if (kind.high_half)
            value = {raw[HALF-1:0], {HALF{1'b0}}};
        else
            value = cand[kind.size];
    end
endmodule

// File: rtl/be_load_extender.sv
module be_load_extender
    import ldx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64,
    localparam int OFF_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [1:0]        ld_size,
    input  logic              ld_signed,
    input  logic              ld_high,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    ld_kind_t          kind;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] ext;

    assign kind = '{size: ld_size_e'(ld_size), sign_ext: ld_signed, high_half: ld_high};

    ldx_lane_pick #(.DATA_W(DATA_W)) u_pick (
        .word (mem_word),
        .off  (addr[OFF_W-1:0]),
        .size (eff_size(kind)),
        .raw  (raw)
    );

    ldx_extend #(.DATA_W(DATA_W)) u_ext (
        .raw   (raw),
        .kind  (kind),
        .value (ext)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= ext;
        end
    end

    // R2: strobe latency
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: hold when idle
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R8: high half clears low half
    a_r8_low_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ld_high) |=> (out_data[DATA_W/2-1:0] == '0));
    // R6: unsigned byte zero-extends
    a_r6_byte_zext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ld_high && ld_size == 2'd0 && !ld_signed) |=> (out_data[DATA_W-1:8] == '0));
    // R5: signed byte sign-extends
    a_r5_byte_sext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ld_high && ld_size == 2'd0 && ld_signed)
        |=> (out_data[DATA_W-1:8] == {(DATA_W-8){out_data[7]}}));
    // R7: octa pass-through
    a_r7_octa_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ld_high && ld_size == 2'd3) |=> (out_data == $past(mem_word)));
endmodule

// File: tb/be_load_extender_tb.sv
`timescale 1ns/1ps
module be_load_extender_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] addr;
    logic [63:0] mem_word;
    logic [1:0]  ld_size;
    logic        ld_signed;
    logic        ld_high;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    logic        m_valid;
    logic [63:0] m_data;

    always #10 clk = ~clk;

    be_load_extender u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .addr(addr),
        .mem_word(mem_word), .ld_size(ld_size), .ld_signed(ld_signed),
        .ld_high(ld_high), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] ref_load(logic [63:0] a, logic [63:0] w,
                                             logic [1:0] sz, logic sg, logic hi);
        int n, k;
        logic [63:0] v, m;
        if (hi) begin
            k = a[2] ? 4 : 0;
            v = (w >> (8 * (4 - k))) & 64'h0000_0000_FFFF_FFFF;
            return v << 32;
        end
        n = 1 << sz;
        k = (int'(a[2:0]) / n) * n;
        v = w >> (8 * (8 - n - k));
        if (n < 8) begin
            m = (64'd1 << (8 * n)) - 64'd1;
            v = v & m;
            if (sg && v[8*n-1]) v = v | ~m;
        end
        return v;
    endfunction

    task automatic step(input logic r, input logic v, input logic [63:0] a,
                        input logic [63:0] w, input logic [1:0] sz,
                        input logic sg, input logic hi, input string tag);
        rst = r; in_valid = v; addr = a; mem_word = w;
        ld_size = sz; ld_signed = sg; ld_high = hi;
        @(posedge clk);
        if (r) begin m_valid = 1'b0; m_data = '0; end
        else begin
            m_valid = v;
            if (v) m_data = ref_load(a, w, sz, sg, hi);
        end
        @(negedge clk);
        checks++;
        if (out_valid !== m_valid || out_data !== m_data) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     tag, out_valid, out_data, m_valid, m_data);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [63:0] W0 = 64'h80FF_7F01_C3A5_5A3C;

    initial begin
        @(negedge clk);
        step(1, 1, 64'h5, W0, 2'd3, 0, 0, "R1 reset");
        step(1, 0, 64'h0, W0, 2'd0, 0, 0, "R1 reset");
        step(0, 1, 64'h0, W0, 2'd0, 0, 0, "R3 R6 byte offset0 unsigned");
        step(0, 1, 64'h0, W0, 2'd0, 1, 0, "R3 R5 byte offset0 signed");
        step(0, 1, 64'h3, W0, 2'd0, 1, 0, "R3 R5 byte offset3 positive");
        step(0, 1, 64'h7, W0, 2'd0, 0, 0, "R3 byte offset7");
        step(0, 0, 64'h2, 64'hFFFF, 2'd0, 1, 0, "R9 R2 idle hold");
        step(0, 0, 64'h1, 64'h0, 2'd3, 0, 1, "R9 idle hold again");
        step(0, 1, 64'h5, W0, 2'd1, 1, 0, "R4 R5 wyde odd address signed");
        step(0, 1, 64'h5, W0, 2'd1, 0, 0, "R4 R6 wyde odd address unsigned");
        step(0, 1, 64'h2, W0, 2'd1, 1, 0, "R5 wyde positive");
        step(0, 1, 64'h6, W0, 2'd2, 1, 0, "R4 R5 tetra unaligned signed");
        step(0, 1, 64'h1, W0, 2'd2, 0, 0, "R4 R6 tetra high unsigned");
        step(0, 1, 64'hFFFF_0000_0000_0008, W0, 2'd0, 0, 0, "R4 high address bits ignored");
        step(0, 1, 64'h7, W0, 2'd3, 1, 0, "R7 octa signed flag ignored");
        step(0, 1, 64'h3, W0, 2'd3, 0, 0, "R7 octa unsigned");
        step(0, 1, 64'h1, W0, 2'd0, 1, 1, "R8 high tetra lane0");
        step(0, 1, 64'h6, W0, 2'd3, 0, 1, "R8 high tetra lane1");
        step(0, 0, 64'h0, 64'h0, 2'd0, 0, 0, "R2 R9 idle after high");
        step(1, 1, 64'h0, W0, 2'd3, 0, 0, "R1 reset mid-run");
        for (int i = 0; i < 600; i++) begin
            step(0, ($urandom % 4) != 0, {$urandom, $urandom}, {$urandom, $urandom},
                 2'($urandom), 1'($urandom), ($urandom % 5) == 0,
                 "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule